// File: doc/BRIEF.md
# Packed SIMD Add-Subtract Unit

This unit is the arithmetic part of a packed-data extension. Every operation reads two 32-bit source words (`src_b`, `src_c`) and two 32-bit destination words (`dst_a`, `dst_d`). It returns up to two 32-bit results, each with its own write enable. The operations are:

- dual 32-bit add/subtract and quad 16-bit add/subtract, in plain and accumulating forms;
- widening unsigned byte add/subtract, in plain and accumulating forms;
- unsigned halving averages on 16-bit or 8-bit lanes;
- a byte sum of absolute differences;
- a clamp-and-pack from signed 16-bit lanes to unsigned bytes.

A two-bit add/subtract code sets the direction for each result on its own. On the 16-bit lane forms, the first source can be rearranged before it is used.

The surrounding pipeline reads its register file, presents the operands together with `in_valid`, and writes the results back on the next cycle wherever `wr_a` or `wr_d` is set. Instruction decode and register storage live outside this block.

Top module: `simd_as_unit`

## Requirements
- R1: On `op` 0 (dual 32-bit), `res_a = src_b ± src_c` and `res_d = src_b ± src_c`, with arithmetic modulo 2^32. `addsub[1]` sets the direction for `res_a` and `addsub[0]` sets it for `res_d`; a value of 1 means subtract. Both results are written.
- R2: On `op` 1 (quad 16-bit), each 16-bit lane gives `b_lane ± c_lane` modulo 2^16, with the same per-result `addsub` bits. No carry or borrow crosses from the low lane into the high lane.
- R3: On `op` 1 and `op` 3, `src_b` is rearranged by `swz` before use: 0 keeps it as is, 1 exchanges the halves, 2 puts the high half in both lanes, and 3 puts the low half in both lanes. `src_c` is always used unchanged.
- R4: `op` 2 and `op` 3 are the accumulating forms of `op` 0 and `op` 1. `res_a` is `dst_a` plus the lane result built for it, and `res_d` is `dst_d` plus its lane result, each sum wrapping at the lane width.
- R5: `op` 4 works on unsigned bytes and widens them. `res_a` is {b[31:24]±c[31:24], b[23:16]±c[23:16]} and `res_d` is {b[15:8]±c[15:8], b[7:0]±c[7:0]}, each 16-bit field wrapping modulo 2^16. `op` 5 adds these fields lane by lane into `dst_a` and `dst_d`.
- R6: `op` 6 and `op` 7 take the unsigned average of each 16-bit lane pair, and `op` 8 and `op` 9 do the same on each byte pair. The even codes round down and the odd codes round up. Only `res_a` is written.
- R7: On `op` 10, `res_a` is the sum of the four unsigned byte absolute differences |b_i − c_i|. `res_d` is `dst_d` plus that sum. Both results are written.
- R8: On `op` 11, each signed 16-bit half is clamped to the range 0..255. The four bytes are packed as {clamp(b[31:16]), clamp(b[15:0]), clamp(c[31:16]), clamp(c[15:0])}, from the top byte down. Only `res_a` is written.
- R9: The results and the enables appear on the clock edge after the operands are accepted with `in_valid`. Without `in_valid`, and for `op` 12..15, both enables are 0.
- R10: Synchronous active-high `rst` clears both enables and both results.
- R11: `swz` has no effect on any operation other than `op` 1 and `op` 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and operation are valid this cycle |
| op | input | 4 | Operation code (0..11 defined) |
| addsub | input | 2 | Bit 1 sets the direction for `res_a`, bit 0 for `res_d`; 1 = subtract |
| swz | input | 2 | Rearrangement of `src_b` for the 16-bit lane forms |
| src_b | input | 32 | First source word |
| src_c | input | 32 | Second source word |
| dst_a | input | 32 | Current contents of the first destination |
| dst_d | input | 32 | Current contents of the second destination |
| res_a | output | 32 | First result |
| res_d | output | 32 | Second result |
| wr_a | output | 1 | Write enable for `res_a` |
| wr_d | output | 1 | Write enable for `res_d` |

## Verification
On every cycle, the assertions check the following:
- an enable is never raised without a valid operation one cycle earlier;
- the second enable never appears without the first;
- reserved codes stay silent;
- the byte reduction writes the same sum to both results, with the old contents of `dst_d` added to the second;
- every average lane falls between its two inputs;
- the reduction never exceeds four full-scale bytes.

Only the bench scenarios can show the exact values: lane isolation under wraparound, each swizzle pattern, the rounding direction of the averages, the clamp at both ends, and the fact that `swz` is ignored by the 32-bit operations.

// File: rtl/simd_as_pkg.sv
package simd_as_pkg;

    localparam int WORD_W = 32;
    localparam int HALF_W = WORD_W / 2;
    localparam int BYTE_W = 8;
    localparam int N_BYTES = WORD_W / BYTE_W;

    typedef enum logic [3:0] {
        OP_ADD32  = 4'd0,
        OP_ADD16  = 4'd1,
        OP_ACC32  = 4'd2,
        OP_ACC16  = 4'd3,
        OP_ADDE8  = 4'd4,
        OP_ACCE8  = 4'd5,
        OP_AVG16F = 4'd6,
        OP_AVG16C = 4'd7,
        OP_AVG8F  = 4'd8,
        OP_AVG8C  = 4'd9,
        OP_SAD8   = 4'd10,
        OP_SAT8   = 4'd11
    } simd_op_e;

    typedef enum logic [1:0] {
        SWZ_KEEP = 2'd0,
        SWZ_SWAP = 2'd1,
        SWZ_HIGH = 2'd2,
        SWZ_LOW  = 2'd3
    } swz_e;

    typedef struct packed {
        logic [WORD_W-1:0] res_a;
        logic [WORD_W-1:0] res_d;
        logic              wr_a;
        logic              wr_d;
    } simd_result_t;

    // Rearrange the two halves of the first source.
    function automatic logic [WORD_W-1:0] apply_swz(logic [WORD_W-1:0] w, swz_e s);
        logic [HALF_W-1:0] hi, lo;
        hi = w[WORD_W-1:HALF_W];
        lo = w[HALF_W-1:0];
        case (s)
            SWZ_SWAP: return {lo, hi};
            SWZ_HIGH: return {hi, hi};
            SWZ_LOW:  return {lo, lo};
            default:  return {hi, lo};
        endcase
    endfunction

    // Zero-extend the upper two bytes into two half-word lanes.
    function automatic logic [WORD_W-1:0] widen_upper(logic [WORD_W-1:0] w);
        return {{(HALF_W-BYTE_W){1'b0}}, w[WORD_W-1 -: BYTE_W],
                {(HALF_W-BYTE_W){1'b0}}, w[HALF_W +: BYTE_W]};
    endfunction

    // Zero-extend the lower two bytes into two half-word lanes.
    function automatic logic [WORD_W-1:0] widen_lower(logic [WORD_W-1:0] w);
        return {{(HALF_W-BYTE_W){1'b0}}, w[BYTE_W +: BYTE_W],
                {(HALF_W-BYTE_W){1'b0}}, w[0 +: BYTE_W]};
    endfunction

    // Clamp a signed half-word to the unsigned byte range.
    function automatic logic [BYTE_W-1:0] clamp_u8(logic [HALF_W-1:0] v);
        if (v[HALF_W-1])
            return '0;
        else if (|v[HALF_W-2:BYTE_W])
            return '1;
        else
            return v[BYTE_W-1:0];
    endfunction

endpackage

// File: rtl/simd_as_lanes.sv
module simd_as_lanes #(
    parameter int W  = 32,
    parameter int LW = 16
) (
    input  logic [W-1:0] xa,
    input  logic [W-1:0] ya,
    input  logic [W-1:0] xd,
    input  logic [W-1:0] yd,
    input  logic [W-1:0] acc_a,
    input  logic [W-1:0] acc_d,
    input  logic         sub_a,
    input  logic         sub_d,
    input  logic         acc_en,
    output logic [W-1:0] sum_a,
    output logic [W-1:0] sum_d
);
    localparam int NL = W / LW;

    for (genvar g = 0; g < NL; g++) begin : g_lane
        logic [LW-1:0] pa, pd, ba, bd;
        assign pa = sub_a ? (xa[g*LW +: LW] - ya[g*LW +: LW]) : (xa[g*LW +: LW] + ya[g*LW +: LW]);
        assign pd = sub_d ? (xd[g*LW +: LW] - yd[g*LW +: LW]) : (xd[g*LW +: LW] + yd[g*LW +: LW]);
        assign ba = acc_en ? acc_a[g*LW +: LW] : '0;
        assign bd = acc_en ? acc_d[g*LW +: LW] : '0;
        assign sum_a[g*LW +: LW] = ba + pa;
        assign sum_d[g*LW +: LW] = bd + pd;
    end

endmodule

// File: rtl/simd_as_reduce.sv
module simd_as_reduce
    import simd_as_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    input  logic [W-1:0] dacc,
    input  logic         rnd_up,
    output logic [W-1:0] avg16,
    output logic [W-1:0] avg8,
    output logic [W-1:0] sad,
    output logic [W-1:0] sad_acc,
    output logic [W-1:0] sat
);
    localparam int NH = W / HALF_W;
    localparam int NB = W / BYTE_W;

    for (genvar h = 0; h < NH; h++) begin : g_avg16
        logic [HALF_W:0] s;
        logic [HALF_W-1:0] x, y, r;
        assign x = b[h*HALF_W +: HALF_W];
        assign y = c[h*HALF_W +: HALF_W];
        assign s = {1'b0, x} + {1'b0, y} + {{HALF_W{1'b0}}, rnd_up};
        assign r = HALF_W'(s >> 1);
        assign avg16[h*HALF_W +: HALF_W] = r;
        always_comb begin
            AST_AVG16_RANGE: assert ((r >= x || r >= y) && (r <= x || r <= y)); // R6
        end
    end

    logic [BYTE_W-1:0] absd [NB];

    for (genvar i = 0; i < NB; i++) begin : g_byte
        logic [BYTE_W:0] s;
        logic [BYTE_W-1:0] x, y, r;
        assign x = b[i*BYTE_W +: BYTE_W];
        assign y = c[i*BYTE_W +: BYTE_W];
        assign s = {1'b0, x} + {1'b0, y} + {{BYTE_W{1'b0}}, rnd_up};
        assign r = BYTE_W'(s >> 1);
        assign avg8[i*BYTE_W +: BYTE_W] = r;
        assign absd[i] = (x > y) ? (x - y) : (y - x);
        always_comb begin
            AST_AVG8_RANGE: assert ((r >= x || r >= y) && (r <= x || r <= y)); // R6
        end
    end

    always_comb begin
        sad = '0;
        for (int i = 0; i < NB; i++)
            sad = sad + W'(absd[i]);
        sad_acc = dacc + sad;
    end

    always_comb begin
        AST_SAD_BOUND: assert (sad <= W'(NB * ((1 << BYTE_W) - 1))); // R7
    end

    always_comb begin
        sat = {clamp_u8(b[W-1:HALF_W]), clamp_u8(b[HALF_W-1:0]),
               clamp_u8(c[W-1:HALF_W]), clamp_u8(c[HALF_W-1:0])};
    end

endmodule

// File: rtl/simd_as_unit.sv
module simd_as_unit
    import simd_as_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [3:0]        op,
    input  logic [1:0]        addsub,
    input  logic [1:0]        swz,
    input  logic [WORD_W-1:0] src_b,
    input  logic [WORD_W-1:0] src_c,
    input  logic [WORD_W-1:0] dst_a,
    input  logic [WORD_W-1:0] dst_d,
    output logic [WORD_W-1:0] res_a,
    output logic [WORD_W-1:0] res_d,
    output logic              wr_a,
    output logic              wr_d
);
    simd_op_e op_e;
    logic widen, acc16, acc32, rnd_up;
    logic [WORD_W-1:0] bsw, l16_xa, l16_ya, l16_xd, l16_yd;
    logic [WORD_W-1:0] s32_a, s32_d, s16_a, s16_d;
    logic [WORD_W-1:0] avg16, avg8, sad, sad_acc, sat;
    simd_result_t nxt;

    always_comb begin
        op_e   = simd_op_e'(op);
        widen  = (op_e == OP_ADDE8) || (op_e == OP_ACCE8);
        acc16  = (op_e == OP_ACC16) || (op_e == OP_ACCE8);
        acc32  = (op_e == OP_ACC32);
        rnd_up = (op_e == OP_AVG16C) || (op_e == OP_AVG8C);
        bsw    = apply_swz(src_b, swz_e'(swz));
        l16_xa = widen ? widen_upper(src_b) : bsw;
        l16_ya = widen ? widen_upper(src_c) : src_c;
        l16_xd = widen ? widen_lower(src_b) : bsw;
        l16_yd = widen ? widen_lower(src_c) : src_c;
    end

    simd_as_lanes #(.W(WORD_W), .LW(WORD_W)) u_lanes32 (
        .xa(src_b), .ya(src_c), .xd(src_b), .yd(src_c),
        .acc_a(dst_a), .acc_d(dst_d),
        .sub_a(addsub[1]), .sub_d(addsub[0]), .acc_en(acc32),
        .sum_a(s32_a), .sum_d(s32_d)
    );

    simd_as_lanes #(.W(WORD_W), .LW(HALF_W)) u_lanes16 (
        .xa(l16_xa), .ya(l16_ya), .xd(l16_xd), .yd(l16_yd),
        .acc_a(dst_a), .acc_d(dst_d),
        .sub_a(addsub[1]), .sub_d(addsub[0]), .acc_en(acc16),
        .sum_a(s16_a), .sum_d(s16_d)
    );

    simd_as_reduce #(.W(WORD_W)) u_reduce (
        .b(src_b), .c(src_c), .dacc(dst_d), .rnd_up(rnd_up),
        .avg16(avg16), .avg8(avg8), .sad(sad), .sad_acc(sad_acc), .sat(sat)
    );

    always_comb begin
        nxt = '0;
        case (op_e)
            OP_ADD32, OP_ACC32:
                nxt = '{res_a: s32_a, res_d: s32_d, wr_a: 1'b1, wr_d: 1'b1};
            OP_ADD16, OP_ACC16, OP_ADDE8, OP_ACCE8:
                nxt = '{res_a: s16_a, res_d: s16_d, wr_a: 1'b1, wr_d: 1'b1};
            OP_AVG16F, OP_AVG16C:
                nxt = '{res_a: avg16, res_d: '0, wr_a: 1'b1, wr_d: 1'b0};
            OP_AVG8F, OP_AVG8C:
                nxt = '{res_a: avg8, res_d: '0, wr_a: 1'b1, wr_d: 1'b0};
            OP_SAD8:
                nxt = '{res_a: sad, res_d: sad_acc, wr_a: 1'b1, wr_d: 1'b1};
            OP_SAT8:
                nxt = '{res_a: sat, res_d: '0, wr_a: 1'b1, wr_d: 1'b0};
            default:
                nxt = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_a <= '0;
            res_d <= '0;
            wr_a  <= 1'b0;
            wr_d  <= 1'b0;
        end else begin
            wr_a <= in_valid && nxt.wr_a;
            wr_d <= in_valid && nxt.wr_d;
            if (in_valid) begin
                res_a <= nxt.res_a;
                res_d <= nxt.res_d;
            end
        end
    end

    AST_WR_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        (wr_a || wr_d) |-> $past(in_valid)); // R9

    AST_D_IMPLIES_A: assert property (@(posedge clk) disable iff (rst)
        wr_d |-> wr_a); // R9

    AST_RESERVED_SILENT: assert property (@(posedge clk) disable iff (rst)
        ($past(in_valid) && ($past(op) >= 4'd12)) |-> (!wr_a && !wr_d)); // R9

    AST_SAD_SHARED_SUM: assert property (@(posedge clk) disable iff (rst)
        ($past(in_valid) && ($past(op) == 4'd10)) |-> (res_d == $past(dst_d) + res_a)); // R7

endmodule

// File: tb/simd_as_unit_bench.sv
`timescale 1ns/1ps
module simd_as_unit_bench;
    localparam time CLK_P = 8ns;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [3:0] op = '0;
    logic [1:0] addsub = '0, swz = '0;
    logic [31:0] src_b = '0, src_c = '0, dst_a = '0, dst_d = '0;
    logic [31:0] res_a, res_d;
    logic wr_a, wr_d;

    int checks = 0, errors = 0, cyc = 0;
    bit done = 0;

    typedef struct {
        int          stamp;
        logic [31:0] ea, ed;
        logic        wa, wd;
        string       tag;
    } exp_t;
    exp_t q[$];

    always #(CLK_P/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    simd_as_unit u_simd_as_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .addsub(addsub),
        .swz(swz), .src_b(src_b), .src_c(src_c), .dst_a(dst_a), .dst_d(dst_d),
        .res_a(res_a), .res_d(res_d), .wr_a(wr_a), .wr_d(wr_d)
    );

    function automatic logic [7:0] clampb(logic [15:0] v);
        if ($signed(v) < 0) return 8'h00;
        if ($signed(v) > 255) return 8'hFF;
        return v[7:0];
    endfunction

    function automatic void model(input int o, input logic [1:0] as, input logic [1:0] sw,
                                  input logic [31:0] b, input logic [31:0] c,
                                  input logic [31:0] a, input logic [31:0] d,
                                  output logic [31:0] ea, output logic [31:0] ed,
                                  output logic wa, output logic wd);
        logic [31:0] bs;
        logic [15:0] x, y;
        int sum;
        ea = '0; ed = '0; wa = 1; wd = 1;
        case (sw)
            2'd1: bs = {b[15:0], b[31:16]};
            2'd2: bs = {b[31:16], b[31:16]};
            2'd3: bs = {b[15:0], b[15:0]};
            default: bs = b;
        endcase
        case (o)
            0, 2: begin
                ea = (o == 2 ? a : 32'd0) + (as[1] ? b - c : b + c);
                ed = (o == 2 ? d : 32'd0) + (as[0] ? b - c : b + c);
            end
            1, 3: for (int i = 0; i < 2; i++) begin
                x = bs[16*i +: 16]; y = c[16*i +: 16];
                ea[16*i +: 16] = (o == 3 ? a[16*i +: 16] : 16'd0) + (as[1] ? x - y : x + y);
                ed[16*i +: 16] = (o == 3 ? d[16*i +: 16] : 16'd0) + (as[0] ? x - y : x + y);
            end
            4, 5: for (int i = 0; i < 2; i++) begin
                x = {8'd0, b[8*(i+2) +: 8]}; y = {8'd0, c[8*(i+2) +: 8]};
                ea[16*i +: 16] = (o == 5 ? a[16*i +: 16] : 16'd0) + (as[1] ? x - y : x + y);
                x = {8'd0, b[8*i +: 8]}; y = {8'd0, c[8*i +: 8]};
                ed[16*i +: 16] = (o == 5 ? d[16*i +: 16] : 16'd0) + (as[0] ? x - y : x + y);
            end
            6, 7: begin
                wd = 0;
                for (int i = 0; i < 2; i++)
                    ea[16*i +: 16] = 16'((int'(b[16*i +: 16]) + int'(c[16*i +: 16]) + (o == 7 ? 1 : 0)) / 2);
            end
            8, 9: begin
                wd = 0;
                for (int i = 0; i < 4; i++)
                    ea[8*i +: 8] = 8'((int'(b[8*i +: 8]) + int'(c[8*i +: 8]) + (o == 9 ? 1 : 0)) / 2);
            end
            10: begin
                sum = 0;
                for (int i = 0; i < 4; i++)
                    sum += (b[8*i +: 8] > c[8*i +: 8]) ? int'(b[8*i +: 8]) - int'(c[8*i +: 8])
                                                       : int'(c[8*i +: 8]) - int'(b[8*i +: 8]);
                ea = 32'(sum);
                ed = d + 32'(sum);
            end
            11: begin
                wd = 0;
                ea = {clampb(b[31:16]), clampb(b[15:0]), clampb(c[31:16]), clampb(c[15:0])};
            end
            default: begin wa = 0; wd = 0; end
        endcase
    endfunction

    task automatic send(input bit v, input int o, input logic [1:0] as, input logic [1:0] sw,
                        input logic [31:0] b, input logic [31:0] c,
                        input logic [31:0] a, input logic [31:0] d, input string tag);
        exp_t e;
        @(negedge clk);
        in_valid = v; op = 4'(o); addsub = as; swz = sw;
        src_b = b; src_c = c; dst_a = a; dst_d = d;
        model(o, as, sw, b, c, a, d, e.ea, e.ed, e.wa, e.wd);
        if (!v) begin e.wa = 0; e.wd = 0; end
        e.stamp = cyc; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 0;
    endtask

    // Monitor: pops the item due this cycle and compares it at the ports.
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            #1;
            if (q.size() > 0 && q[0].stamp + 1 == cyc) begin
                e = q.pop_front();
                checks++;
                if (wr_a !== e.wa || wr_d !== e.wd ||
                    (e.wa && res_a !== e.ea) || (e.wd && res_d !== e.ed)) begin
                    errors++;
                    $display("FAIL %s: actual wa=%0b wd=%0b a=%h d=%h expected wa=%0b wd=%0b a=%h d=%h",
                             e.tag, wr_a, wr_d, res_a, res_d, e.wa, e.wd, e.ea, e.ed);
                end
            end
        end
    end

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            errors++;
            $display("FAIL R9 watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        checks++;  // R10 reset state
        if (wr_a !== 0 || wr_d !== 0 || res_a !== 0 || res_d !== 0) begin
            errors++;
            $display("FAIL R10: actual wa=%0b wd=%0b a=%h d=%h expected all zero", wr_a, wr_d, res_a, res_d);
        end
        // R1 dual 32-bit, every addsub code, wraparound
        send(1, 0, 2'd0, 2'd0, 32'h7FFF_FFFF, 32'h1, 0, 0, "R1 AA wrap");
        send(1, 0, 2'd1, 2'd0, 32'd10, 32'd3, 0, 0, "R1 AS");
        send(1, 0, 2'd2, 2'd0, 32'd10, 32'd3, 0, 0, "R1 SA");
        send(1, 0, 2'd3, 2'd0, 32'd0, 32'd1, 0, 0, "R1 SS borrow");
        // R11 swizzle ignored on 32-bit ops
        send(1, 0, 2'd1, 2'd2, 32'h1234_5678, 32'h0000_0001, 0, 0, "R11 swz on op0");
        send(1, 2, 2'd0, 2'd3, 32'h1234_5678, 32'h0000_0001, 32'h10, 32'h20, "R11 swz on op2");
        // R2 lane isolation
        send(1, 1, 2'd1, 2'd0, 32'hFFFF_0001, 32'h0001_0002, 0, 0, "R2 no carry");
        send(1, 1, 2'd2, 2'd0, 32'h8000_FFFF, 32'h8000_0001, 0, 0, "R2 lane wrap");
        // R3 swizzle patterns
        send(1, 1, 2'd0, 2'd1, 32'h1234_5678, 32'h0001_0002, 0, 0, "R3 exchange");
        send(1, 1, 2'd0, 2'd2, 32'h1234_5678, 32'h0001_0002, 0, 0, "R3 clone high");
        send(1, 1, 2'd3, 2'd3, 32'h1234_5678, 32'h0001_0002, 0, 0, "R3 clone low");
        // R4 accumulate
        send(1, 2, 2'd1, 2'd0, 32'd100, 32'd40, 32'd1000, 32'hFFFF_FFFF, "R4 acc32");
        send(1, 3, 2'd2, 2'd1, 32'h0010_0020, 32'h0001_0002, 32'hFFFF_0005, 32'h0003_0004, "R4 acc16 swz");
        // R5 widening byte forms
        send(1, 4, 2'd0, 2'd0, 32'hFF10_8002, 32'h0120_8003, 0, 0, "R5 widen AA");
        send(1, 4, 2'd3, 2'd0, 32'hFF10_8002, 32'h0120_8003, 0, 0, "R5 widen SS");
        send(1, 5, 2'd1, 2'd0, 32'h0102_0304, 32'h0506_0708, 32'h0100_0200, 32'h0300_0400, "R5 widen acc");
        // R6 averages
        send(1, 6, 2'd0, 2'd0, 32'hFFFF_0003, 32'hFFFE_0000, 0, 0, "R6 avg16 floor");
        send(1, 7, 2'd0, 2'd0, 32'hFFFF_0003, 32'hFFFE_0000, 0, 0, "R6 avg16 ceil");
        send(1, 8, 2'd0, 2'd0, 32'hFF01_0380, 32'hFE00_0081, 0, 0, "R6 avg8 floor");
        send(1, 9, 2'd0, 2'd0, 32'hFF01_0380, 32'hFE00_0081, 0, 0, "R6 avg8 ceil");
        // R7 SAD
        send(1, 10, 2'd0, 2'd0, 32'h00FF_1020, 32'hFF00_2010, 32'h5, 32'd1000, "R7 sad");
        // R8 clamp and pack
        send(1, 11, 2'd0, 2'd0, 32'h8000_00FF, 32'h0100_007F, 0, 0, "R8 sat");
        // R9 reserved code and missing valid
        send(1, 12, 2'd0, 2'd0, 32'h1, 32'h1, 0, 0, "R9 reserved op");
        send(0, 0, 2'd0, 2'd0, 32'h1, 32'h1, 0, 0, "R9 no valid");
        idle();
        idle();
        idle();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule